// File: doc/BRIEF.md
# Stop-and-Wait ARQ Link Controller

This block moves fixed-size payloads from a source to a sink across a deliberately unreliable internal channel. It delivers each payload exactly once and in order. A transmitter state machine takes one payload at a time and adds a one-bit alternating sequence number. It computes a CRC-8 over the sequence bit and the payload, places the check value after the payload, and writes the frame into a forward buffer. A channel stage owns that buffer and the reverse response buffer, and it raises a ready flag for whichever side must act next.

The channel can corrupt a frame or lose a response. A free-running 16-bit LFSR compares its state against two programmable thresholds to make these choices. A corrupted frame has exactly one bit flipped, at a position also taken from the LFSR. The receiver state machine recomputes the CRC with its own serial engine. On a match it returns an ACK, and on a mismatch it returns a NACK. The transmitter advances on a matching ACK. It resends the stored frame unchanged on a NACK, or when no response arrives within a fixed number of cycles. Duplicate frames caused by lost ACKs are recognised by their sequence bit. They are acknowledged but not delivered again.

Top module: `arq_link_ctrl`

## Requirements
- R1: After reset, src_ready is 1, dlv_valid is 0, and all three counters are 0.
- R2: Each frame is the sequence bit, then the payload, then a CRC-8 (polynomial x^8+x^2+x+1, register cleared to zero, bits taken MSB first over the sequence bit followed by the payload). With both thresholds at 0, an accepted payload appears unchanged on dlv_data with a one-cycle dlv_valid pulse exactly 2*PAYLOAD_W+5 cycles after the accepting clock edge (69 cycles at the default width).
- R3: Only one payload is outstanding at a time. src_ready is 0 from the cycle after acceptance until the matching ACK has been consumed.
- R4: A forward corruption event happens when the LFSR state is less than or equal to fwd_thresh, and a response is lost when the LFSR state is less than or equal to rev_thresh. A threshold of 0 never triggers and 16'hFFFF always triggers. A corruption flips exactly one frame bit.
- R5: A frame whose check value does not match is not delivered and is answered with a NACK. The transmitter resends the same frame, and cnt_retx and cnt_nack each rise by one for that NACK.
- R6: If no response reaches the transmitter, it resends the stored frame exactly TIMEOUT cycles after its previous send. cnt_retx rises by one and cnt_nack is unchanged.
- R7: A frame that repeats the sequence bit of the last delivered frame is acknowledged but not delivered again. The transmitter then advances and src_ready returns to 1.
- R8: cnt_delivered rises by one with every dlv_valid pulse. Under random corruption and loss on both paths, every accepted payload is delivered exactly once and in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | 1 | Source offers a payload |
| src_data | input | PAYLOAD_W | Offered payload |
| src_ready | output | 1 | Transmitter idle, will accept on this edge |
| fwd_thresh | input | 16 | Forward corruption threshold |
| rev_thresh | input | 16 | Response loss threshold |
| dlv_valid | output | 1 | One-cycle pulse for a delivered payload |
| dlv_data | output | PAYLOAD_W | Delivered payload |
| cnt_delivered | output | CNT_W | Payloads delivered |
| cnt_retx | output | CNT_W | Frames resent (NACK or timeout) |
| cnt_nack | output | CNT_W | NACKs received by the transmitter |

## Verification
With clean thresholds, a payload's delivery falls exactly 2*PAYLOAD_W+5 edges after the edge that accepted it. The bench records the cycle index of each acceptance and requires the dlv_valid pulse at that offset. When every response is lost, consecutive resends must be TIMEOUT cycles apart, so the bench timestamps each step of cnt_retx and compares the gaps. All other results are due on the same edge as the event that causes them: a counter steps together with its dlv_valid pulse or resend. The per-clock model therefore compares counters against its own tallies at every falling edge, half a period after the register update.

// File: rtl/arq_pkg.sv
package arq_pkg;

    localparam int LFSR_W = 16;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_CALC,
        TX_WAIT
    } tx_state_e;

    typedef enum logic {
        RX_IDLE,
        RX_CHECK
    } rx_state_e;

    typedef struct packed {
        logic ack;
        logic seq;
    } resp_t;

    // maximal-length Fibonacci LFSR, taps 16/14/13/11
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/arq_crc_serial.sv
module arq_crc_serial #(
    parameter int MSG_W = 33,
    parameter int CRC_W = 8,
    parameter logic [CRC_W-1:0] POLY = 'h07
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [MSG_W-1:0] msg,
    output logic             done,
    output logic [CRC_W-1:0] crc
);
    localparam int CNT_W = $clog2(MSG_W + 1);

    logic [MSG_W-1:0] sh;
    logic [CNT_W-1:0] left;
    logic             busy;
    logic             fb;

    assign fb = crc[CRC_W-1] ^ sh[MSG_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            crc  <= '0;
            left <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                sh   <= msg;
                crc  <= '0;
                left <= CNT_W'(MSG_W);
                busy <= 1'b1;
            end else if (busy) begin
                sh   <= sh << 1;
                crc  <= {crc[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
                left <= left - 1'b1;
                if (left == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R2
    crc_done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2
    crc_no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !start);

endmodule

// File: rtl/arq_channel.sv
module arq_channel
    import arq_pkg::*;
#(
    parameter int FRAME_W = 41,
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LFSR_W-1:0]  fwd_thresh,
    input  logic [LFSR_W-1:0]  rev_thresh,
    input  logic               tx_push,
    input  logic [FRAME_W-1:0] tx_frame,
    input  logic               rx_pop,
    output logic               fwd_rdy,
    output logic [FRAME_W-1:0] fwd_frame,
    input  logic               rx_resp_push,
    input  resp_t              rx_resp,
    input  logic               tx_resp_pop,
    output logic               rev_rdy,
    output resp_t              rev_resp
);
    logic [LFSR_W-1:0]  lfsr;
    logic [LFSR_W-1:0]  rot;
    logic [LFSR_W-1:0]  pos;
    logic [FRAME_W-1:0] mask;
    logic               hit_fwd;
    logic               hit_rev;

    assign hit_fwd = (lfsr <= fwd_thresh);
    assign hit_rev = (lfsr <= rev_thresh);
    assign rot     = {lfsr[7:0], lfsr[15:8]};
    assign pos     = rot % LFSR_W'(FRAME_W);
    assign mask    = FRAME_W'(1) << pos;

    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr      <= SEED;
            fwd_rdy   <= 1'b0;
            fwd_frame <= '0;
            rev_rdy   <= 1'b0;
            rev_resp  <= '0;
        end else begin
            lfsr <= lfsr_step(lfsr);
            if (tx_push) begin
                fwd_frame <= hit_fwd ? (tx_frame ^ mask) : tx_frame;
                fwd_rdy   <= 1'b1;
            end else if (rx_pop) begin
                fwd_rdy <= 1'b0;
            end
            if (rx_resp_push && !hit_rev) begin
                rev_resp <= rx_resp;
                rev_rdy  <= 1'b1;
            end else if (tx_resp_pop) begin
                rev_rdy <= 1'b0;
            end
        end
    end

    // R4
    clean_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_push && fwd_thresh == '0) |=> (fwd_frame == $past(tx_frame)));

    // R4
    one_flip_chk: assert property (@(posedge clk) disable iff (rst)
        tx_push |=> ($countones(fwd_frame ^ $past(tx_frame)) <= 1));

endmodule

// File: rtl/arq_tx.sv
module arq_tx
    import arq_pkg::*;
#(
    parameter int PAYLOAD_W = 32,
    parameter int CRC_W     = 8,
    parameter logic [CRC_W-1:0] POLY = 'h07,
    parameter int TIMEOUT   = 128,
    parameter int CNT_W     = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         src_valid,
    input  logic [PAYLOAD_W-1:0]         src_data,
    output logic                         src_ready,
    output logic                         tx_push,
    output logic [PAYLOAD_W+CRC_W:0]     tx_frame,
    input  logic                         rev_rdy,
    input  resp_t                        rev_resp,
    output logic                         resp_pop,
    output logic [CNT_W-1:0]             cnt_retx,
    output logic [CNT_W-1:0]             cnt_nack
);
    localparam int MSG_W   = PAYLOAD_W + 1;
    localparam int FRAME_W = MSG_W + CRC_W;
    localparam int TMR_W   = $clog2(TIMEOUT + 1);

    tx_state_e              state;
    logic                   seq;
    logic [PAYLOAD_W-1:0]   payload_q;
    logic [FRAME_W-1:0]     frame_q;
    logic [TMR_W-1:0]       timer;
    logic                   crc_start;
    logic                   crc_done;
    logic [CRC_W-1:0]       crc_val;
    logic                   ack_ok;
    logic                   nack_in;
    logic                   tmo;
    logic                   resend;

    assign crc_start = (state == TX_IDLE) && src_valid;
    assign src_ready = (state == TX_IDLE);
    assign ack_ok    = (state == TX_WAIT) && rev_rdy && rev_resp.ack && (rev_resp.seq == seq);
    assign nack_in   = (state == TX_WAIT) && rev_rdy && !rev_resp.ack;
    assign tmo       = (state == TX_WAIT) && (timer == TMR_W'(TIMEOUT - 1));
    assign resend    = !ack_ok && (nack_in || tmo);
    assign resp_pop  = (state == TX_WAIT) && rev_rdy;
    assign tx_push   = ((state == TX_CALC) && crc_done) || resend;
    assign tx_frame  = (state == TX_CALC) ? {seq, payload_q, crc_val} : frame_q;

    arq_crc_serial #(.MSG_W(MSG_W), .CRC_W(CRC_W), .POLY(POLY)) u_crc (
        .clk   (clk),
        .rst   (rst),
        .start (crc_start),
        .msg   ({seq, src_data}),
        .done  (crc_done),
        .crc   (crc_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= TX_IDLE;
            seq       <= 1'b0;
            payload_q <= '0;
            frame_q   <= '0;
            timer     <= '0;
            cnt_retx  <= '0;
            cnt_nack  <= '0;
        end else begin
            unique case (state)
                TX_IDLE: if (src_valid) begin
                    payload_q <= src_data;
                    state     <= TX_CALC;
                end
                TX_CALC: if (crc_done) begin
                    frame_q <= {seq, payload_q, crc_val};
                    timer   <= '0;
                    state   <= TX_WAIT;
                end
                TX_WAIT: begin
                    if (ack_ok) begin
                        seq   <= ~seq;
                        state <= TX_IDLE;
                    end else if (nack_in) begin
                        cnt_retx <= cnt_retx + 1'b1;
                        cnt_nack <= cnt_nack + 1'b1;
                        timer    <= '0;
                    end else if (tmo) begin
                        cnt_retx <= cnt_retx + 1'b1;
                        timer    <= '0;
                    end else begin
                        timer <= timer + 1'b1;
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    // R3
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (src_valid && src_ready) |=> !src_ready);

    // R5
    retx_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_retx != $past(cnt_retx)) |-> (cnt_retx == $past(cnt_retx) + 1'b1));

endmodule

// File: rtl/arq_rx.sv
module arq_rx
    import arq_pkg::*;
#(
    parameter int PAYLOAD_W = 32,
    parameter int CRC_W     = 8,
    parameter logic [CRC_W-1:0] POLY = 'h07,
    parameter int CNT_W     = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     fwd_rdy,
    input  logic [PAYLOAD_W+CRC_W:0] fwd_frame,
    output logic                     rx_pop,
    output logic                     resp_push,
    output resp_t                    resp,
    output logic                     dlv_valid,
    output logic [PAYLOAD_W-1:0]     dlv_data,
    output logic [CNT_W-1:0]         cnt_delivered
);
    localparam int MSG_W   = PAYLOAD_W + 1;
    localparam int FRAME_W = MSG_W + CRC_W;

    rx_state_e          state;
    logic [FRAME_W-1:0] frame_q;
    logic               expect_seq;
    logic               crc_done;
    logic [CRC_W-1:0]   crc_val;
    logic               good;
    logic               fseq;

    assign rx_pop    = (state == RX_IDLE) && fwd_rdy;
    assign good      = (crc_val == frame_q[CRC_W-1:0]);
    assign fseq      = frame_q[FRAME_W-1];
    assign resp_push = (state == RX_CHECK) && crc_done;
    assign resp      = '{ack: good, seq: fseq};

    arq_crc_serial #(.MSG_W(MSG_W), .CRC_W(CRC_W), .POLY(POLY)) u_crc (
        .clk   (clk),
        .rst   (rst),
        .start (rx_pop),
        .msg   (fwd_frame[FRAME_W-1:CRC_W]),
        .done  (crc_done),
        .crc   (crc_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= RX_IDLE;
            frame_q       <= '0;
            expect_seq    <= 1'b0;
            dlv_valid     <= 1'b0;
            dlv_data      <= '0;
            cnt_delivered <= '0;
        end else begin
            dlv_valid <= 1'b0;
            unique case (state)
                RX_IDLE: if (fwd_rdy) begin
                    frame_q <= fwd_frame;
                    state   <= RX_CHECK;
                end
                RX_CHECK: if (crc_done) begin
                    if (good && (fseq == expect_seq)) begin
                        dlv_valid     <= 1'b1;
                        dlv_data      <= frame_q[FRAME_W-2:CRC_W];
                        cnt_delivered <= cnt_delivered + 1'b1;
                        expect_seq    <= ~expect_seq;
                    end
                    state <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    // R8
    dlv_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        dlv_valid |=> !dlv_valid);

    // R8
    deliv_count_chk: assert property (@(posedge clk) disable iff (rst)
        dlv_valid |-> (cnt_delivered != $past(cnt_delivered)));

endmodule

// File: rtl/arq_link_ctrl.sv
module arq_link_ctrl
    import arq_pkg::*;
#(
    parameter int PAYLOAD_W = 32,
    parameter int CRC_W     = 8,
    parameter logic [CRC_W-1:0] CRC_POLY = 8'h07,
    parameter int TIMEOUT   = 128,
    parameter int CNT_W     = 16,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 src_valid,
    input  logic [PAYLOAD_W-1:0] src_data,
    output logic                 src_ready,
    input  logic [LFSR_W-1:0]    fwd_thresh,
    input  logic [LFSR_W-1:0]    rev_thresh,
    output logic                 dlv_valid,
    output logic [PAYLOAD_W-1:0] dlv_data,
    output logic [CNT_W-1:0]     cnt_delivered,
    output logic [CNT_W-1:0]     cnt_retx,
    output logic [CNT_W-1:0]     cnt_nack
);
    localparam int FRAME_W = PAYLOAD_W + 1 + CRC_W;

    logic               tx_push;
    logic [FRAME_W-1:0] tx_frame;
    logic               rx_pop;
    logic               fwd_rdy;
    logic [FRAME_W-1:0] fwd_frame;
    logic               rx_resp_push;
    resp_t              rx_resp;
    logic               tx_resp_pop;
    logic               rev_rdy;
    resp_t              rev_resp;

    arq_tx #(
        .PAYLOAD_W(PAYLOAD_W), .CRC_W(CRC_W), .POLY(CRC_POLY),
        .TIMEOUT(TIMEOUT), .CNT_W(CNT_W)
    ) u_tx (
        .clk       (clk),
        .rst       (rst),
        .src_valid (src_valid),
        .src_data  (src_data),
        .src_ready (src_ready),
        .tx_push   (tx_push),
        .tx_frame  (tx_frame),
        .rev_rdy   (rev_rdy),
        .rev_resp  (rev_resp),
        .resp_pop  (tx_resp_pop),
        .cnt_retx  (cnt_retx),
        .cnt_nack  (cnt_nack)
    );

    arq_channel #(.FRAME_W(FRAME_W), .SEED(LFSR_SEED)) u_chan (
        .clk          (clk),
        .rst          (rst),
        .fwd_thresh   (fwd_thresh),
        .rev_thresh   (rev_thresh),
        .tx_push      (tx_push),
        .tx_frame     (tx_frame),
        .rx_pop       (rx_pop),
        .fwd_rdy      (fwd_rdy),
        .fwd_frame    (fwd_frame),
        .rx_resp_push (rx_resp_push),
        .rx_resp      (rx_resp),
        .tx_resp_pop  (tx_resp_pop),
        .rev_rdy      (rev_rdy),
        .rev_resp     (rev_resp)
    );

    arq_rx #(
        .PAYLOAD_W(PAYLOAD_W), .CRC_W(CRC_W), .POLY(CRC_POLY), .CNT_W(CNT_W)
    ) u_rx (
        .clk           (clk),
        .rst           (rst),
        .fwd_rdy       (fwd_rdy),
        .fwd_frame     (fwd_frame),
        .rx_pop        (rx_pop),
        .resp_push     (rx_resp_push),
        .resp          (rx_resp),
        .dlv_valid     (dlv_valid),
        .dlv_data      (dlv_data),
        .cnt_delivered (cnt_delivered)
    );

endmodule

// File: tb/arq_link_ctrl_tb.sv
`timescale 1ns/1ps
module arq_link_ctrl_tb;
    localparam int PW      = 32;
    localparam int CW      = 16;
    localparam int TIMEOUT = 128;
    localparam int LAT     = 2 * PW + 5;
    localparam int LIMIT   = 150000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          src_valid = 1'b0;
    logic [PW-1:0] src_data = '0;
    logic          src_ready;
    logic [15:0]   fwd_thresh = '0;
    logic [15:0]   rev_thresh = '0;
    logic          dlv_valid;
    logic [PW-1:0] dlv_data;
    logic [CW-1:0] cnt_delivered, cnt_retx, cnt_nack;

    always #2.5 clk = ~clk;

    arq_link_ctrl #(.PAYLOAD_W(PW), .TIMEOUT(TIMEOUT), .CNT_W(CW)) u_dut (
        .clk(clk), .rst(rst), .src_valid(src_valid), .src_data(src_data),
        .src_ready(src_ready), .fwd_thresh(fwd_thresh), .rev_thresh(rev_thresh),
        .dlv_valid(dlv_valid), .dlv_data(dlv_data), .cnt_delivered(cnt_delivered),
        .cnt_retx(cnt_retx), .cnt_nack(cnt_nack)
    );

    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    logic [PW-1:0] exp_q[$];
    int          model_deliv = 0;
    int          last_accept = 0;
    bit          run = 0;
    bit          lat_on = 0;
    bit          gap_on = 0;
    int          last_step = -1;
    int          prev_retx = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // per-clock reference comparison
    always @(negedge clk) begin
        if (run) begin
            if (dlv_valid) begin
                chk(exp_q.size() > 0, "R8 delivery without pending payload", dlv_data, 0);
                if (exp_q.size() > 0) begin
                    chk(dlv_data == exp_q[0], "R8 delivered payload order", dlv_data, exp_q[0]);
                    void'(exp_q.pop_front());
                end
                model_deliv++;
                if (lat_on) chk(cyc == last_accept + LAT, "R2 delivery latency", cyc, last_accept + LAT);
            end
            chk(int'(cnt_delivered) == model_deliv, "R8 delivered counter", cnt_delivered, model_deliv);
            chk(cnt_nack <= cnt_retx, "R5 nack not above retx", cnt_nack, cnt_retx);
            if (int'(cnt_retx) != prev_retx) begin
                if (gap_on && last_step >= 0)
                    chk(cyc - last_step == TIMEOUT, "R6 timeout spacing", cyc - last_step, TIMEOUT);
                last_step = cyc;
            end
            prev_retx = int'(cnt_retx);
        end
        if (cyc > LIMIT) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wait_ready();
        while (!src_ready) @(negedge clk);
    endtask

    task automatic send(input logic [PW-1:0] d);
        src_data  = d;
        src_valid = 1'b1;
        while (!src_ready) @(negedge clk);
        exp_q.push_back(d);
        last_accept = cyc + 1;
        @(negedge clk);
        src_valid = 1'b0;
        chk(src_ready == 1'b0, "R3 ready low while outstanding", src_ready, 0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int d0, r0, n0;
        idle(5);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(src_ready == 1'b1, "R1 src_ready", src_ready, 1);
        chk(dlv_valid == 1'b0, "R1 dlv_valid", dlv_valid, 0);
        chk(cnt_delivered == 0 && cnt_retx == 0 && cnt_nack == 0, "R1 counters",
            cnt_delivered + cnt_retx + cnt_nack, 0);
        run = 1;

        // R2 clean channel, several patterns, fixed latency
        lat_on = 1;
        send(32'h0000_0000); wait_ready();
        send(32'hFFFF_FFFF); wait_ready();
        send(32'hA5A5_5A5A); wait_ready();
        send(32'h8000_0001); wait_ready();
        send(32'h1234_5678); wait_ready();
        lat_on = 0;
        chk(cnt_delivered == 5, "R2 all clean payloads delivered", cnt_delivered, 5);
        chk(cnt_retx == 0 && cnt_nack == 0, "R4 zero threshold never corrupts", cnt_retx, 0);

        // R5 every frame corrupted: NACK loop, nothing delivered
        fwd_thresh = 16'hFFFF;
        send(32'hDEAD_BEEF);
        idle(1000);
        chk(cnt_delivered == 5, "R5 corrupted frame not delivered", cnt_delivered, 5);
        chk(cnt_nack > 0, "R4 full threshold always corrupts", cnt_nack, 1);
        chk(cnt_retx == cnt_nack, "R5 retx equals nack", cnt_retx, cnt_nack);
        chk(src_ready == 1'b0, "R3 still waiting during NACK loop", src_ready, 0);
        fwd_thresh = 16'h0000;
        for (int i = 0; i < 1000 && model_deliv < 6; i++) @(negedge clk);
        chk(model_deliv == 6, "R5 resent frame delivered once clean", model_deliv, 6);
        wait_ready();

        // R6/R7 every response lost: timeouts and duplicates
        n0 = int'(cnt_nack);
        rev_thresh = 16'hFFFF;
        gap_on = 1;
        last_step = -1;
        r0 = int'(cnt_retx);
        send(32'hC0FF_EE00);
        idle(TIMEOUT * 8);
        gap_on = 0;
        chk(cnt_delivered == 7, "R7 duplicate not delivered again", cnt_delivered, 7);
        chk(int'(cnt_retx) - r0 >= 6, "R6 timeouts resend", int'(cnt_retx) - r0, 6);
        chk(int'(cnt_nack) == n0, "R6 nack unchanged on timeout", cnt_nack, n0);
        rev_thresh = 16'h0000;
        for (int i = 0; i < 2 * TIMEOUT && !src_ready; i++) @(negedge clk);
        chk(src_ready == 1'b1, "R7 duplicate ACK lets transmitter advance", src_ready, 1);
        chk(cnt_delivered == 7, "R7 no extra delivery after advance", cnt_delivered, 7);

        // R8 random loss on both paths
        fwd_thresh = 16'h3000;
        rev_thresh = 16'h3000;
        d0 = model_deliv;
        for (int k = 0; k < 16; k++) send(32'h5000_0000 + k * 32'h0101_0013);
        wait_ready();
        fwd_thresh = 16'h0000;
        rev_thresh = 16'h0000;
        idle(10);
        chk(model_deliv - d0 == 16, "R8 every payload delivered once", model_deliv - d0, 16);
        chk(exp_q.size() == 0, "R8 nothing left pending", exp_q.size(), 0);
        chk(cnt_retx > 0, "R8 random loss caused resends", cnt_retx, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule